// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. A client offers a data byte with a valid/ready handshake. A separate line-control byte sets the framing: character length, whether a parity bit is added and how it is formed, how many stop bits follow, and a break override. The serial timing comes from an external enable pulse, `tick_i`, that runs at sixteen times the bit rate. The block contains no divisor of its own.

The framing fields are captured at the moment a character is accepted, so software may rewrite the control byte while a frame is on the line. The break field is the one exception: it acts on the output pin at once, in every state, without disturbing the frame timing underneath.

The frame controller has six states. `ST_IDLE` holds the line high with ready asserted. Accepting a character moves it to `ST_START`, which sends the low start bit. After one bit time it moves to `ST_DATA`, which sends the character bits least significant first. After the last data bit it goes to `ST_PARITY` if parity is on, and otherwise straight to `ST_STOP`. `ST_PARITY` always moves on to `ST_STOP`, which sends the first high stop bit. From there the controller returns to `ST_IDLE` when one stop bit is selected, or moves to `ST_STOP_EXT` for the extra full or half stop bit. `ST_STOP_EXT` then returns to `ST_IDLE`. Each move happens on the tick that ends the current bit slot.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset and between frames, `serial_o` is high, `tx_ready_o` is 1 and `busy_o` is 0 (with break clear).
- R2: A character is taken on a clock edge where `tx_valid_i` and `tx_ready_o` are both 1. From the next cycle until the final stop slot has ended, `busy_o` is 1 and `tx_ready_o` is 0, and requests offered in that time are not taken.
- R3: A frame opens with one low start bit. Every full bit lasts exactly 16 `tick_i` pulses counted after acceptance, and the line changes only on a clock edge where `tick_i` is 1.
- R4: Control bits [1:0] select 5, 6, 7 or 8 data bits for codes 00, 01, 10, 11. Only the selected low-order bits of `tx_data_i` are sent, least significant bit first.
- R5: With control bit [2] at 1, one parity bit follows the last data bit and comes before the first stop bit. With bit [2] at 0, no parity bit is sent.
- R6: With control bit [3] at 1, the parity bit makes the count of ones over the data bits plus parity even. With bit [3] at 0, it makes that count odd.
- R7: With control bits [4] and [2] both at 1, the parity bit is the inverse of bit [3]. With bit [2] at 0, bit [4] has no effect on the frame.
- R8: With control bit [5] at 0, one high stop bit of 16 ticks is sent. With bit [5] at 1, the stop time is 32 ticks for 6 to 8 data bits and 24 ticks for 5 data bits.
- R9: While control bit [6] is 1, `serial_o` is 0 in the same cycle, in any state. Clearing the bit restores the level of the frame in progress, whose timing it did not change.
- R10: The control byte is sampled at acceptance. Changes to bits [5:0] during a frame affect only later frames. Bit [7] is unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Enable pulse at 16 times the bit rate |
| line_ctrl_i | input | 8 | Framing control byte (fields in R4 to R10) |
| tx_data_i | input | 8 | Character to send |
| tx_valid_i | input | 1 | Character offered |
| tx_ready_o | output | 1 | Block can take a character |
| serial_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Frame in progress |

## Verification
The properties assume that only the break field of the control byte may move the line outside a tick edge. They also assume that `tick_i` can arrive on any cycle, including back to back. The stimulus changes inputs only at falling clock edges and pulses `tick_i` for one cycle with random gaps of zero to two cycles. Break is raised only between two edges and always cleared before the next tick, so every slot boundary the bench counts is one the controller also sees.

// File: rtl/uft_pkg.sv
package uft_pkg;

    localparam int CTRL_W        = 8;
    localparam int LEN_CODE_W    = 2;
    localparam int MIN_CHAR_BITS = 5;
    localparam int MAX_CHAR_BITS = MIN_CHAR_BITS + (1 << LEN_CODE_W) - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_STOP_EXT
    } tx_state_t;

    typedef struct packed {
        logic                  brk;
        logic                  stop_x;
        logic                  forced;
        logic                  even;
        logic                  par_on;
        logic [LEN_CODE_W-1:0] len_code;
    } line_cfg_t;

    function automatic line_cfg_t decode_ctrl(input logic [CTRL_W-2:0] b);
        line_cfg_t c;
        c.len_code = b[LEN_CODE_W-1:0];
        c.par_on   = b[2];
        c.even     = b[3];
        c.forced   = b[4];
        c.stop_x   = b[5];
        c.brk      = b[6];
        return c;
    endfunction

    function automatic int char_bits(input logic [LEN_CODE_W-1:0] code);
        return MIN_CHAR_BITS + int'(code);
    endfunction

    function automatic logic parity_of(input logic [MAX_CHAR_BITS-1:0] d,
                                       input int n,
                                       input logic even,
                                       input logic forced);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < MAX_CHAR_BITS; i++) begin
            if (i < n) acc = acc ^ d[i];
        end
        if (forced) return ~even;
        return even ? acc : ~acc;
    endfunction

endpackage

// File: rtl/uft_slot_timer.sv
module uft_slot_timer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    input  logic half_i,
    output logic slot_end_o
);

    localparam int CNT_W = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int HALF_TICKS = (TICKS_PER_BIT / 2 > 0) ? TICKS_PER_BIT / 2 : 1;
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(TICKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_TICKS - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit      = half_i ? HALF_LAST : FULL_LAST;
    assign slot_end_o = tick_i && !hold_i && (cnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold_i) begin
            cnt <= '0;
        end else if (tick_i) begin
            cnt <= slot_end_o ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/uft_char_shifter.sv
module uft_char_shifter
    import uft_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     shift_i,
    input  logic [MAX_CHAR_BITS-1:0] data_i,
    input  logic [LEN_CODE_W-1:0]    len_code_i,
    input  logic                     even_i,
    input  logic                     forced_i,
    output logic                     bit_o,
    output logic                     last_o,
    output logic                     parity_o
);

    localparam int LEFT_W = $clog2(MAX_CHAR_BITS + 1);

    logic [MAX_CHAR_BITS-1:0] shreg;
    logic [LEFT_W-1:0]        left;
    logic                     par_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
            par_q <= 1'b0;
        end else if (load_i) begin
            shreg <= data_i;
            left  <= LEFT_W'(char_bits(len_code_i));
            par_q <= parity_of(data_i, char_bits(len_code_i), even_i, forced_i);
        end else if (shift_i) begin
            shreg <= {1'b0, shreg[MAX_CHAR_BITS-1:1]};
            left  <= left - 1'b1;
        end
    end

    assign bit_o    = shreg[0];
    assign last_o   = (left == LEFT_W'(1));
    assign parity_o = par_q;

endmodule

// File: rtl/uft_tx_ctrl.sv
module uft_tx_ctrl
    import uft_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic slot_end_i,
    input  logic last_data_i,
    input  logic par_on_i,
    input  logic stop_x_i,
    input  logic short_char_i,
    input  logic data_bit_i,
    input  logic parity_bit_i,
    output logic load_o,
    output logic shift_o,
    output logic hold_o,
    output logic half_o,
    output logic line_o,
    output logic ready_o,
    output logic busy_o
);

    tx_state_t state;
    tx_state_t nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (valid_i)    nxt = ST_START;
            ST_START:    if (slot_end_i) nxt = ST_DATA;
            ST_DATA:     if (slot_end_i && last_data_i)
                             nxt = par_on_i ? ST_PARITY : ST_STOP;
            ST_PARITY:   if (slot_end_i) nxt = ST_STOP;
            ST_STOP:     if (slot_end_i) nxt = stop_x_i ? ST_STOP_EXT : ST_IDLE;
            ST_STOP_EXT: if (slot_end_i) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o  = 1'b0;
        shift_o = 1'b0;
        hold_o  = 1'b0;
        half_o  = 1'b0;
        line_o  = 1'b1;
        ready_o = 1'b0;
        busy_o  = 1'b1;
        unique case (state)
            ST_IDLE: begin
                hold_o  = 1'b1;
                ready_o = 1'b1;
                busy_o  = 1'b0;
                load_o  = valid_i;
            end
            ST_START: line_o = 1'b0;
            ST_DATA: begin
                line_o  = data_bit_i;
                shift_o = slot_end_i && !last_data_i;
            end
            ST_PARITY:   line_o = parity_bit_i;
            ST_STOP:     line_o = 1'b1;
            ST_STOP_EXT: half_o = short_char_i;
            default: begin
                hold_o = 1'b1;
                busy_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uft_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_i,
    input  logic [CTRL_W-1:0]        line_ctrl_i,
    input  logic [MAX_CHAR_BITS-1:0] tx_data_i,
    input  logic                     tx_valid_i,
    output logic                     tx_ready_o,
    output logic                     serial_o,
    output logic                     busy_o
);

    line_cfg_t live_cfg;
    logic      unused_ctrl_top;

    logic par_on_q, stop_x_q, short_q;
    logic load, shift, hold, half, slot_end;
    logic data_bit, last_data, parity_bit, line;

    assign live_cfg        = decode_ctrl(line_ctrl_i[CTRL_W-2:0]);
    assign unused_ctrl_top = line_ctrl_i[CTRL_W-1];

    // framing fields captured at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_on_q <= 1'b0;
            stop_x_q <= 1'b0;
            short_q  <= 1'b1;
        end else if (load) begin
            par_on_q <= live_cfg.par_on;
            stop_x_q <= live_cfg.stop_x;
            short_q  <= (live_cfg.len_code == '0);
        end
    end

    uft_slot_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .hold_i     (hold),
        .half_i     (half),
        .slot_end_o (slot_end)
    );

    uft_char_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .shift_i    (shift),
        .data_i     (tx_data_i),
        .len_code_i (live_cfg.len_code),
        .even_i     (live_cfg.even),
        .forced_i   (live_cfg.forced),
        .bit_o      (data_bit),
        .last_o     (last_data),
        .parity_o   (parity_bit)
    );

    uft_tx_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (tx_valid_i),
        .slot_end_i   (slot_end),
        .last_data_i  (last_data),
        .par_on_i     (par_on_q),
        .stop_x_i     (stop_x_q),
        .short_char_i (short_q),
        .data_bit_i   (data_bit),
        .parity_bit_i (parity_bit),
        .load_o       (load),
        .shift_o      (shift),
        .hold_o       (hold),
        .half_o       (half),
        .line_o       (line),
        .ready_o      (tx_ready_o),
        .busy_o       (busy_o)
    );

    // break overrides the pin only
    assign serial_o = live_cfg.brk ? 1'b0 : line;

endmodule

// File: rtl/uft_checker.sv
module uft_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic brk_i,
    input logic valid_i,
    input logic ready_i,
    input logic txd_i,
    input logic busy_i
);

    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !brk_i) |-> txd_i);

    a_r2_accept_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_i) |=> (busy_i && !ready_i));

    a_r2_no_ready_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !ready_i);

    a_r3_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_i) && !brk_i) |-> !txd_i);

    a_r3_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i) && !$past(tick_i) && !brk_i && !$past(brk_i))
        |-> $stable(txd_i));

    a_r8_last_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_i) |-> ($past(txd_i) || $past(brk_i)));

    a_r9_break_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk_i |-> !txd_i);

endmodule

bind uart_frame_tx uft_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .brk_i   (line_ctrl_i[6]),
    .valid_i (tx_valid_i),
    .ready_i (tx_ready_o),
    .txd_i   (serial_o),
    .busy_i  (busy_o)
);

// File: tb/uart_frame_tx_test.sv
`timescale 1ns/1ps
module uart_frame_tx_test;

    localparam int TPB = 16;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_i;
    logic [7:0] line_ctrl_i;
    logic [7:0] tx_data_i;
    logic       tx_valid_i;
    logic       tx_ready_o;
    logic       serial_o;
    logic       busy_o;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic  seg_lvl [0:15];
    int    seg_len [0:15];
    string seg_tag [0:15];
    int    nseg;

    always #2.5 clk = ~clk;

    uart_frame_tx #(.TICKS_PER_BIT(TPB)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .line_ctrl_i (line_ctrl_i),
        .tx_data_i   (tx_data_i),
        .tx_valid_i  (tx_valid_i),
        .tx_ready_o  (tx_ready_o),
        .serial_o    (serial_o),
        .busy_o      (busy_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG && !done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog R2: cycles %0d, expected fewer than %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic add_seg(input logic lvl, input int len, input string tag);
        seg_lvl[nseg] = lvl;
        seg_len[nseg] = len;
        seg_tag[nseg] = tag;
        nseg++;
    endtask

    function automatic logic exp_parity(input logic [7:0] d, input logic [7:0] c);
        logic p;
        int n;
        n = 5 + int'(c[1:0]);
        p = 1'b0;
        for (int i = 0; i < n; i++) p = p ^ d[i];
        if (c[4]) return ~c[3];
        return c[3] ? p : ~p;
    endfunction

    task automatic build_frame(input logic [7:0] d, input logic [7:0] c, input bit scr);
        int n;
        string sfx;
        string t;
        n = 5 + int'(c[1:0]);
        sfx = scr ? " R10" : "";
        nseg = 0;
        add_seg(1'b0, TPB, {"R3 start", sfx});
        for (int i = 0; i < n; i++) add_seg(d[i], TPB, {"R3 R4 data", sfx});
        if (c[2]) begin
            if (c[4]) t = "R5 R7 parity";
            else      t = "R5 R6 parity";
            add_seg(exp_parity(d, c), TPB, {t, sfx});
        end
        if (c[4] && !c[2]) t = "R8 R7 stop";
        else               t = "R8 stop";
        add_seg(1'b1, TPB, {t, sfx});
        if (c[5]) add_seg(1'b1, (n == 5) ? TPB / 2 : TPB, {"R8 extra stop", sfx});
    endtask

    task automatic sample(input int s);
        chk({seg_tag[s], " line"}, serial_o, seg_lvl[s]);
        chk("R2 busy in frame", busy_o, 1'b1);
        chk("R2 ready low in frame", tx_ready_o, 1'b0);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic [7:0] c,
                              input bit scr, input bit hold, input bit brk);
        int bseg;
        int gap;
        bseg = -1;
        build_frame(d, c, scr);
        if (brk) bseg = int'($urandom_range(nseg - 1, 0));
        line_ctrl_i = c;
        tx_data_i   = d;
        tx_valid_i  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 accepted busy", busy_o, 1'b1);
        chk("R2 accepted ready", tx_ready_o, 1'b0);
        if (hold) tx_data_i = ~d;
        else      tx_valid_i = 1'b0;
        if (scr) line_ctrl_i = 8'($urandom) & 8'hBF;
        for (int s = 0; s < nseg; s++) begin
            if (s == nseg - 1) tx_valid_i = 1'b0;
            for (int t = 0; t < seg_len[s]; t++) begin
                gap = int'($urandom_range(2, 0));
                repeat (gap) begin
                    sample(s);
                    @(negedge clk);
                end
                sample(s);
                if (s == bseg && t == 0) begin
                    line_ctrl_i[6] = 1'b1;
                    #1;
                    chk("R9 break low mid frame", serial_o, 1'b0);
                    line_ctrl_i[6] = 1'b0;
                    #1;
                    chk("R9 frame level restored", serial_o, seg_lvl[s]);
                end
                tick_i = 1'b1;
                @(posedge clk);
                @(negedge clk);
                tick_i = 1'b0;
            end
        end
        chk("R1 R2 ready after frame", tx_ready_o, 1'b1);
        chk("R1 R2 idle not busy", busy_o, 1'b0);
        chk("R1 idle line high", serial_o, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd24680));
        rst_n       = 1'b0;
        tick_i      = 1'b0;
        line_ctrl_i = 8'h00;
        tx_data_i   = 8'h00;
        tx_valid_i  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset line", serial_o, 1'b1);
        chk("R1 reset ready", tx_ready_o, 1'b1);
        chk("R1 reset busy", busy_o, 1'b0);

        // break while idle
        line_ctrl_i = 8'h40;
        #1;
        chk("R9 break low while idle", serial_o, 1'b0);
        @(negedge clk);
        chk("R9 break holds, no frame", busy_o, 1'b0);
        line_ctrl_i = 8'h00;
        #1;
        chk("R9 release to idle high", serial_o, 1'b1);
        @(negedge clk);

        // directed corner cases
        send_frame(8'hA5, 8'h0F, 1'b0, 1'b0, 1'b0); // 8 bits even parity
        send_frame(8'hFF, 8'h20, 1'b0, 1'b0, 1'b0); // 5 bits, 1.5 stop, masking
        send_frame(8'h2C, 8'h21, 1'b0, 1'b0, 1'b0); // 6 bits, two stop
        send_frame(8'h00, 8'h16, 1'b0, 1'b0, 1'b0); // forced parity, even sel 0 -> 1
        send_frame(8'h7F, 8'h1E, 1'b0, 1'b0, 1'b0); // forced parity, even sel 1 -> 0
        send_frame(8'h3C, 8'h13, 1'b0, 1'b0, 1'b0); // forced bit with parity off
        send_frame(8'h00, 8'h07, 1'b0, 1'b0, 1'b0); // odd parity of zero -> 1
        send_frame(8'h55, 8'h03, 1'b0, 1'b0, 1'b1); // break mid frame
        send_frame(8'h1B, 8'h00, 1'b1, 1'b0, 1'b0); // control rewritten in frame
        send_frame(8'hC3, 8'h2F, 1'b0, 1'b1, 1'b0); // valid held while busy

        // constrained random frames
        for (int k = 0; k < 40; k++) begin
            send_frame(8'($urandom), 8'($urandom) & 8'h3F,
                       1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                       ($urandom_range(3, 0) == 0));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule